// File: doc/BRIEF.md
# Cycloconverter Half-Cycle Synchronizer

This block times the bidirectional switches of a high-frequency-link cycloconverter against the transformer half-cycles produced by the front-end phase-shifted bridge. It watches the gate drive of the leading leg of that bridge. Every transition of that gate, rising or falling, marks the start of a transformer half-cycle. From that transition the block derives one sampling instant, set by two programmable delays counted in system clocks.

The first delay, `delayA`, sets how long the delayed leg gate lags the original. The exclusive-OR of the two forms a train of pulses at twice the switching rate, and each pulse ends `delayA` cycles after the edge that started it. The second delay, `delayB`, runs from the trailing edge of each such pulse and ends in a one-cycle sampling strobe. On that strobe a register captures the sinusoidal PWM command bit. This gives a modulation stream whose edges fall only on half-cycle boundaries. The strobe also toggles a switch-gate flop, so the gate runs at half the strobe rate.

The command bit arrives from another timing domain, so it passes through a two-stage synchronizer first. Both delay settings are clamped to the range 1 to `HALF_CYCLES-1`. This keeps each delay counter to at most one pending interval.

Top module: `pdm_sync`

## Requirements
- R1: While `rstN` is low, and after it rises, `pwmOut` and `swGate` are 0. A reset during a pending interval cancels that interval, so no strobe follows it.
- R2: Suppose a transition of `legGate` is first seen at clock edge 1. Then the outputs update at clock edge `a1+a2+2` and at no earlier edge, where a1 and a2 are the clamped values of `delayA` and `delayB`. Each transition gives exactly one update.
- R3: At the update edge, `pwmOut` takes the level that `spwmIn` held at least two clock edges before that edge. A level that first appears one edge before the update edge is not captured.
- R4: Between update edges `pwmOut` holds its value, whatever `spwmIn` does.
- R5: `swGate` inverts at every update edge and at no other edge. Starting from reset with `legGate` low, `swGate` therefore equals the level `legGate` took at the transition that caused the update.
- R6: A `delayA` value of 0 acts as 1. A value above `HALF_CYCLES-1` acts as `HALF_CYCLES-1`.
- R7: A `delayB` value of 0 acts as 1. A value above `HALF_CYCLES-1` acts as `HALF_CYCLES-1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| legGate | input | 1 | Leading-leg gate drive of the front bridge, synchronous to clk; transitions at least `HALF_CYCLES` cycles apart |
| spwmIn | input | 1 | Sinusoidal PWM command bit, asynchronous |
| delayA | input | DLY_W | First delay in clock cycles (pulse width of the doubled train) |
| delayB | input | DLY_W | Second delay in clock cycles (from pulse end to strobe) |
| pwmOut | output | 1 | Command bit resampled on half-cycle boundaries |
| swGate | output | 1 | Bidirectional switch gate, half the strobe rate |

## Verification
The hardest case to reach from the ports is the synchronizer boundary. This is where a command bit changes one or two clock edges before the sampling edge. The bench reaches it by computing the update edge from the clamped delays and then flipping `spwmIn` at an exact cycle offset inside that window. In one case the flip must be missed and in the other it must be caught. The clamp limits are reached with delay settings of zero and of far more than a half period, and the resulting update edge is checked to the cycle.

// File: rtl/pdm_sync_pkg.sv
package pdm_sync_pkg;

  // Strobes passed from the timing control to the datapath.
  typedef struct packed {
    logic sampleStb;   // one-cycle sampling instant
  } pdm_strobe_t;

endpackage

// File: rtl/pdm_edge_delay.sv
// Turns a one-cycle trigger into a one-cycle pulse dly cycles later.
// Only one interval may be pending at a time.
module pdm_edge_delay #(
  parameter int DLY_W   = 8,
  parameter int MAX_DLY = 39
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trig,
  input  logic [DLY_W-1:0] dly,
  output logic             fire
);

  logic [DLY_W-1:0] cnt;
  logic             busy;

  assign fire = busy && (cnt == DLY_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (trig) begin
      busy <= 1'b1;
      cnt  <= dly;
    end else if (busy) begin
      cnt <= cnt - DLY_W'(1);
      if (cnt == DLY_W'(1)) busy <= 1'b0;
    end
  end

  // R2: a new trigger never lands on an interval that is still running
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    trig |-> (!busy || fire));

  // R6 / R7: a running count stays inside the clamped range
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (cnt != '0 && cnt <= DLY_W'(MAX_DLY)));

endmodule

// File: rtl/pdm_sync_ctrl.sv
// Timing control: edge detection, first delay, XOR doubling, second delay.
module pdm_sync_ctrl
  import pdm_sync_pkg::*;
#(
  parameter int DLY_W       = 8,
  parameter int HALF_CYCLES = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             legGate,
  input  logic [DLY_W-1:0] delayA,
  input  logic [DLY_W-1:0] delayB,
  output pdm_strobe_t      stb
);

  localparam int MAX_DLY = HALF_CYCLES - 1;
  localparam int STAGES  = 2;

  logic gatePrev, refDly, xorPrev;
  logic gateEdge, xorNow, xorFall;

  logic             trigArr [STAGES];
  logic [DLY_W-1:0] rawArr  [STAGES];
  logic [DLY_W-1:0] dlyArr  [STAGES];
  logic             fireArr [STAGES];

  assign gateEdge = legGate ^ gatePrev;
  assign xorNow   = gatePrev ^ refDly;
  assign xorFall  = xorPrev & ~xorNow;

  assign trigArr[0] = gateEdge;
  assign trigArr[1] = xorFall;
  assign rawArr[0]  = delayA;
  assign rawArr[1]  = delayB;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    // R6 / R7: keep each setting inside [1, HALF_CYCLES-1]
    always_comb begin
      if (rawArr[g] == '0)
        dlyArr[g] = DLY_W'(1);
      else if (rawArr[g] > DLY_W'(MAX_DLY))
        dlyArr[g] = DLY_W'(MAX_DLY);
      else
        dlyArr[g] = rawArr[g];
    end

    pdm_edge_delay #(
      .DLY_W  (DLY_W),
      .MAX_DLY(MAX_DLY)
    ) u_dly (
      .clk (clk),
      .rstN(rstN),
      .trig(trigArr[g]),
      .dly (dlyArr[g]),
      .fire(fireArr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gatePrev <= 1'b0;
      refDly   <= 1'b0;
      xorPrev  <= 1'b0;
    end else begin
      gatePrev <= legGate;
      refDly   <= refDly ^ fireArr[0];
      xorPrev  <= xorNow;
    end
  end

  assign stb.sampleStb = fireArr[1];

  // R2: every pulse of the doubled train starts on a leg-gate transition
  a_r2_xor_from_gate: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xorNow) |-> $past(gateEdge));

endmodule

// File: rtl/pdm_sync_dp.sv
// Datapath: synchronizer, sampling register, switch-gate halving flop.
module pdm_sync_dp
  import pdm_sync_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        spwmIn,
  input  pdm_strobe_t stb,
  output logic        pwmOut,
  output logic        swGate
);

  logic syncA, syncB;
  logic sampleStb;

  assign sampleStb = stb.sampleStb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA  <= 1'b0;
      syncB  <= 1'b0;
      pwmOut <= 1'b0;
      swGate <= 1'b0;
    end else begin
      syncA <= spwmIn;
      syncB <= syncA;
      if (sampleStb) begin
        pwmOut <= syncB;
        swGate <= ~swGate;
      end
    end
  end

  // R4: the sampled bit holds when no strobe occurred
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(sampleStb) |-> $stable(pwmOut));

  // R5: the switch gate inverts after every strobe
  a_r5_toggle: assert property (@(posedge clk) disable iff (!rstN)
    $past(sampleStb) |-> (swGate != $past(swGate)));

endmodule

// File: rtl/pdm_sync.sv
module pdm_sync
  import pdm_sync_pkg::*;
#(
  parameter int DLY_W       = 8,
  parameter int HALF_CYCLES = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             legGate,
  input  logic             spwmIn,
  input  logic [DLY_W-1:0] delayA,
  input  logic [DLY_W-1:0] delayB,
  output logic             pwmOut,
  output logic             swGate
);

  pdm_strobe_t stb;

  pdm_sync_ctrl #(
    .DLY_W      (DLY_W),
    .HALF_CYCLES(HALF_CYCLES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .legGate(legGate),
    .delayA (delayA),
    .delayB (delayB),
    .stb    (stb)
  );

  pdm_sync_dp u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .spwmIn(spwmIn),
    .stb   (stb),
    .pwmOut(pwmOut),
    .swGate(swGate)
  );

endmodule

// File: tb/pdm_sync_tb.sv
`timescale 1ns/1ps
module pdm_sync_tb;

  localparam int DLY_W = 8;
  localparam int HALF  = 20;
  localparam int NV    = 8;

  // a1 raw, a2 raw, command bit, expected update edge a1c+a2c+2
  localparam int V_A1 [NV] = '{1, 3, 7, 200, 4,   0, 19, 10};
  localparam int V_A2 [NV] = '{1, 5, 2, 3,   255, 0, 19, 6};
  localparam int V_SP [NV] = '{1, 0, 1, 0,   1,   0, 1,  0};
  localparam int V_N  [NV] = '{4, 10, 11, 24, 25, 4, 40, 18};

  logic clk = 1'b0;
  logic rstN, legGate, spwmIn;
  logic [DLY_W-1:0] delayA, delayB;
  logic pwmOut, swGate;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pdm_sync #(.DLY_W(DLY_W), .HALF_CYCLES(HALF)) u_dut (
    .clk(clk), .rstN(rstN), .legGate(legGate), .spwmIn(spwmIn),
    .delayA(delayA), .delayB(delayB), .pwmOut(pwmOut), .swGate(swGate)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // One leg-gate transition. spwmIn flips at cycle flipAt (0 = never).
  task automatic runEdge(input int a1, input int a2, input logic sp,
                         input int n, input int flipAt, input logic expPwm,
                         input string tag);
    logic prevSw;
    int   win;
    delayA = DLY_W'(a1);
    delayB = DLY_W'(a2);
    spwmIn = sp;
    prevSw = swGate;
    legGate = ~legGate;
    win = ((n > HALF) ? n : HALF) + 4;
    for (int k = 1; k <= win; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == flipAt) spwmIn = ~sp;
      if (k == n - 1) chk({tag, " early"}, swGate, prevSw);
      if (k == n) begin
        chk({tag, " R5 gate"}, swGate, legGate);
        chk("R3 sampled bit", pwmOut, expPwm);
      end
    end
    chk("R4 hold", pwmOut, expPwm);
  endtask

  initial begin
    string tag;
    rstN = 1'b0; legGate = 1'b0; spwmIn = 1'b1;
    delayA = 8'd1; delayB = 8'd1;
    repeat (4) @(negedge clk);
    chk("R1 reset pwm", pwmOut, 1'b0);
    chk("R1 reset gate", swGate, 1'b0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle pwm", pwmOut, 1'b0);
    chk("R1 idle gate", swGate, 1'b0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      if (V_A1[v] < 1 || V_A1[v] > HALF - 1)      tag = "R6";
      else if (V_A2[v] < 1 || V_A2[v] > HALF - 1) tag = "R7";
      else                                        tag = "R2";
      runEdge(V_A1[v], V_A2[v], V_SP[v][0], V_N[v], V_N[v] + 1,
              V_SP[v][0], tag);
    end

    // R3: a change one edge before the update edge is missed
    runEdge(2, 4, pwmOut, 8, 6, pwmOut, "R3 late");
    // R3: a change two edges before the update edge is caught
    runEdge(2, 4, pwmOut, 8, 5, ~pwmOut, "R3 early");

    // R1: reset while an interval is pending cancels it
    delayA = 8'd5; delayB = 8'd5;
    spwmIn = 1'b1;
    legGate = ~legGate;
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    legGate = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 mid reset pwm", pwmOut, 1'b0);
    chk("R1 mid reset gate", swGate, 1'b0);
    rstN = 1'b1;
    repeat (30) @(negedge clk);
    chk("R1 cancelled pwm", pwmOut, 1'b0);
    chk("R1 cancelled gate", swGate, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule